// File: doc/BRIEF.md
# Lookahead refill scheduler for a per-queue head cache

A packet buffer keeps a small head cache in SRAM for each of several queues and refills it from DRAM in fixed blocks of `BLK` bytes. This block sits between the egress scheduler and that cache. Every byte request from the scheduler goes into a delay line `LOOK` cycles long, and the request comes out of the block only once that delay has passed. During the wait the block already knows which bytes are about to be taken. It uses that knowledge to decide which queue the next DRAM block is fetched for.

A refill decision is made once every `BLK` cycles. The block walks the pending requests from the oldest to the newest and keeps a running count for each queue. The first queue whose count passes its current cache occupancy is the earliest queue that will run dry, and it receives the block. If no queue is about to run dry, the block goes to the queue with the largest free space. The block keeps its own per-queue occupancy count: a refill adds `BLK` bytes and each delayed request leaving the delay line removes one byte.

A deeper delay line costs latency but lets the scheduler see shortages coming. With `LOOK = NUM_Q*BLK`, a cache of `3*BLK` bytes per queue is enough to keep every queue from running dry.

Top module: `lookahead_refill_sched`

## Requirements
- R1: A request presented in cycle c with `req_valid_i`=1 appears on `dly_valid_o`/`dly_qid_o` in cycle c+LOOK with the same queue index. A cycle with no request gives `dly_valid_o`=0 LOOK cycles later.
- R2: A slot counter is 0 in the first cycle after reset release and counts modulo BLK. `rd_valid_o` can be 1 only in a cycle where that count is BLK-1, so at most one read is issued per BLK cycles.
- R3: At a decision, the pending requests are scanned oldest first, including the one currently on the delayed output. A running count is kept per queue. The read goes to the queue of the first entry whose running count exceeds that queue's occupancy, among queues with room. This queue wins even over a queue that has more pending requests or more free space.
- R4: When no queue with room is critical, the read goes to the queue with room that has the lowest occupancy (largest deficit CAP minus occupancy). Ties go to the lowest queue index.
- R5: A queue has room when its occupancy is at most CAP-BLK. Only queues with room are refilled. At every decision slot a read is issued exactly when at least one queue has room.
- R6: Occupancy of the queue named by `rd_qid_o` rises by BLK after a read. Occupancy of the queue named by `dly_qid_o` falls by 1 after a delayed request, but a queue already at 0 stays at 0. Both changes apply in the same cycle if they coincide. `occ_o` holds queue q at bits [q*OCC_W +: OCC_W], and no queue exceeds CAP.
- R7: During reset, all occupancies are 0 and `dly_valid_o` and `rd_valid_o` are 0.
- R8: With the default parameters and at most one request per cycle, every delayed request finds at least one byte for its queue in `occ_o` in the cycle it leaves the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Byte request from the scheduler this slot |
| req_qid_i | input | QID_W | Queue of the request |
| dly_valid_o | output | 1 | Request leaving the delay line, served from cache |
| dly_qid_o | output | QID_W | Queue of the served request |
| rd_valid_o | output | 1 | Issue a BLK-byte DRAM read |
| rd_qid_o | output | QID_W | Queue the read refills |
| occ_o | output | NUM_Q*OCC_W | Per-queue cache occupancy in bytes |

## Verification
A short hand-worked sequence from reset places a single request for one queue ahead of two requests for another. This separates choosing the earliest shortage from choosing the largest count, and the decisions that follow tell the deficit fallback and its lowest-index tie rule apart from the critical path. A long idle stretch then drives every queue to its room limit, which shows whether reads stop when none fit. Continuous traffic to one queue, round-robin traffic and rotating bursts of eight per queue then test the no-underrun guarantee and the exact delay under steady, spread and shifting demand, while a port-level occupancy model follows each refill and each serve.

// File: rtl/lars_pkg.sv
package lars_pkg;
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_CRIT = 2'd1,
    PICK_FALL = 2'd2
  } pick_src_e;
endpackage

// File: rtl/lars_delay_line.sv
module lars_delay_line #(
  parameter int LOOK  = 16,
  parameter int QID_W = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic [QID_W-1:0]            in_qid_i,
  output logic [LOOK-1:0]             stg_valid_o,
  output logic [LOOK-1:0][QID_W-1:0]  stg_qid_o
);
  // stage 0 newest, stage LOOK-1 oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_valid_o <= '0;
      stg_qid_o   <= '0;
    end else begin
      stg_valid_o <= {stg_valid_o[LOOK-2:0], in_valid_i};
      stg_qid_o   <= {stg_qid_o[LOOK-2:0], in_qid_i};
    end
  end
endmodule

// File: rtl/lars_occ_track.sv
module lars_occ_track #(
  parameter int NUM_Q = 4,
  parameter int BLK   = 4,
  parameter int CAP   = 12,
  parameter int QID_W = 2,
  parameter int OCC_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fill_valid_i,
  input  logic [QID_W-1:0]             fill_qid_i,
  input  logic                         srv_valid_i,
  input  logic [QID_W-1:0]             srv_qid_i,
  output logic [NUM_Q-1:0][OCC_W-1:0]  occ_o
);
  localparam logic [OCC_W-1:0] BLK_V = OCC_W'(BLK);
  localparam logic [OCC_W-1:0] CAP_V = OCC_W'(CAP);

  logic [NUM_Q-1:0][OCC_W-1:0] occ_q;
  logic [NUM_Q-1:0]            fill_hit, srv_hit;

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      fill_hit[q] = fill_valid_i && (fill_qid_i == QID_W'(q));
      srv_hit[q]  = srv_valid_i && (srv_qid_i == QID_W'(q)) && (occ_q[q] != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
    end else begin
      for (int q = 0; q < NUM_Q; q++) begin
        if (fill_hit[q] && srv_hit[q])  occ_q[q] <= occ_q[q] + BLK_V - OCC_W'(1);
        else if (fill_hit[q])           occ_q[q] <= occ_q[q] + BLK_V;
        else if (srv_hit[q])            occ_q[q] <= occ_q[q] - OCC_W'(1);
      end
    end
  end

  assign occ_o = occ_q;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
    // R6
    occ_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_q[q] <= CAP_V);
  end
endmodule

// File: rtl/lars_refill_pick.sv
module lars_refill_pick import lars_pkg::*; #(
  parameter int NUM_Q = 4,
  parameter int BLK   = 4,
  parameter int CAP   = 12,
  parameter int LOOK  = 16,
  parameter int QID_W = 2,
  parameter int OCC_W = 4
) (
  input  logic [LOOK-1:0]             stg_valid_i,
  input  logic [LOOK-1:0][QID_W-1:0]  stg_qid_i,
  input  logic [NUM_Q-1:0][OCC_W-1:0] occ_i,
  output pick_src_e                   src_o,
  output logic [QID_W-1:0]            qid_o
);
  localparam int CNT_W = $clog2(LOOK + 1);
  localparam int CMP_W = ((CNT_W > OCC_W) ? CNT_W : OCC_W) + 1;
  localparam logic [OCC_W-1:0] CAP_V  = OCC_W'(CAP);
  localparam logic [OCC_W-1:0] ROOM_V = OCC_W'(CAP - BLK);

  logic [NUM_Q-1:0]            room;
  logic [NUM_Q-1:0][CMP_W-1:0] occ_ext, run_cnt;
  logic [NUM_Q-1:0][OCC_W-1:0] deficit;
  logic                        crit_hit, fb_hit;
  logic [QID_W-1:0]            crit_q, fb_q, qi;
  logic [OCC_W-1:0]            best_def;

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      room[q]    = occ_i[q] <= ROOM_V;
      occ_ext[q] = {{(CMP_W-OCC_W){1'b0}}, occ_i[q]};
      deficit[q] = CAP_V - occ_i[q];
    end
  end

  // earliest shortage: walk oldest entry to newest with a running count per queue
  always_comb begin
    run_cnt  = '0;
    crit_hit = 1'b0;
    crit_q   = '0;
    qi       = '0;
    for (int p = LOOK - 1; p >= 0; p--) begin
      if (stg_valid_i[p]) begin
        qi = stg_qid_i[p];
        run_cnt[qi] = run_cnt[qi] + CMP_W'(1);
        if (!crit_hit && room[qi] && (run_cnt[qi] > occ_ext[qi])) begin
          crit_hit = 1'b1;
          crit_q   = qi;
        end
      end
    end
  end

  // largest deficit, strict compare keeps lowest index on ties
  always_comb begin
    fb_hit   = 1'b0;
    fb_q     = '0;
    best_def = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (room[q] && (!fb_hit || deficit[q] > best_def)) begin
        fb_hit   = 1'b1;
        best_def = deficit[q];
        fb_q     = QID_W'(q);
      end
    end
  end

  always_comb begin
    if (crit_hit) begin
      src_o = PICK_CRIT;
      qid_o = crit_q;
    end else if (fb_hit) begin
      src_o = PICK_FALL;
      qid_o = fb_q;
    end else begin
      src_o = PICK_NONE;
      qid_o = '0;
    end
  end
endmodule

// File: rtl/lookahead_refill_sched.sv
module lookahead_refill_sched import lars_pkg::*; #(
  parameter int NUM_Q = 4,
  parameter int BLK   = 4,
  parameter int LOOK  = NUM_Q * BLK,
  parameter int CAP   = 3 * BLK,
  localparam int QID_W = $clog2(NUM_Q),
  localparam int OCC_W = $clog2(CAP + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [QID_W-1:0]         req_qid_i,
  output logic                     dly_valid_o,
  output logic [QID_W-1:0]         dly_qid_o,
  output logic                     rd_valid_o,
  output logic [QID_W-1:0]         rd_qid_o,
  output logic [NUM_Q*OCC_W-1:0]   occ_o
);
  localparam int SLOT_W = $clog2(BLK);
  localparam logic [OCC_W-1:0] ROOM_V = OCC_W'(CAP - BLK);

  logic [SLOT_W-1:0]            slot_q;
  logic                         slot_end;
  logic [LOOK-1:0]              stg_valid;
  logic [LOOK-1:0][QID_W-1:0]   stg_qid;
  logic [NUM_Q-1:0][OCC_W-1:0]  occ;
  pick_src_e                    pick_src;
  logic [QID_W-1:0]             pick_qid;

  assign slot_end = (slot_q == SLOT_W'(BLK - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       slot_q <= '0;
    else if (slot_end) slot_q <= '0;
    else               slot_q <= slot_q + SLOT_W'(1);
  end

  lars_delay_line #(.LOOK(LOOK), .QID_W(QID_W)) u_delay (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_qid_i    (req_qid_i),
    .stg_valid_o (stg_valid),
    .stg_qid_o   (stg_qid)
  );

  lars_refill_pick #(
    .NUM_Q(NUM_Q), .BLK(BLK), .CAP(CAP), .LOOK(LOOK), .QID_W(QID_W), .OCC_W(OCC_W)
  ) u_pick (
    .stg_valid_i (stg_valid),
    .stg_qid_i   (stg_qid),
    .occ_i       (occ),
    .src_o       (pick_src),
    .qid_o       (pick_qid)
  );

  assign dly_valid_o = stg_valid[LOOK-1];
  assign dly_qid_o   = stg_qid[LOOK-1];
  assign rd_valid_o  = slot_end && (pick_src != PICK_NONE);
  assign rd_qid_o    = pick_qid;

  lars_occ_track #(
    .NUM_Q(NUM_Q), .BLK(BLK), .CAP(CAP), .QID_W(QID_W), .OCC_W(OCC_W)
  ) u_occ (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_valid_i (rd_valid_o),
    .fill_qid_i   (rd_qid_o),
    .srv_valid_i  (dly_valid_o),
    .srv_qid_i    (dly_qid_o),
    .occ_o        (occ)
  );

  assign occ_o = occ;

  // checker-side view of room and fallback ordering
  logic [NUM_Q-1:0] occ_room;
  logic             any_room, fb_min_ok;
  always_comb begin
    fb_min_ok = 1'b1;
    for (int q = 0; q < NUM_Q; q++) begin
      occ_room[q] = occ[q] <= ROOM_V;
      if (occ_room[q] && (occ[q] < occ[rd_qid_o])) fb_min_ok = 1'b0;
    end
  end
  assign any_room = |occ_room;

  // R5
  rd_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (occ[rd_qid_o] <= ROOM_V));
  // R5
  idle_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end && !any_room) |-> !rd_valid_o);
  // R5
  busy_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end && any_room) |-> rd_valid_o);
  // R4
  fb_deficit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && pick_src == PICK_FALL) |-> fb_min_ok);
endmodule

// File: tb/lookahead_refill_sched_tb.sv
module lookahead_refill_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_Q = 4;
  localparam int BLK   = 4;
  localparam int LOOK  = 16;
  localparam int CAP   = 12;
  localparam int QID_W = 2;
  localparam int OCC_W = 4;
  localparam int HIST  = 512;

  // row: [8] req v, [7:6] req q, [5] exp rd v, [4:3] exp rd q, [2] exp dly v, [1:0] exp dly q
  localparam logic [8:0] VEC [20] = '{
    {1'b1, 2'd2, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 2'd0},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd2},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1},
    {1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 2'd0}
  };

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   req_valid_i = 1'b0;
  logic [QID_W-1:0]       req_qid_i = '0;
  logic                   dly_valid_o, rd_valid_o;
  logic [QID_W-1:0]       dly_qid_o, rd_qid_o;
  logic [NUM_Q*OCC_W-1:0] occ_o;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;
  logic             hv [HIST];
  logic [QID_W-1:0] hq [HIST];
  int m_occ [NUM_Q];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lookahead_refill_sched #(.NUM_Q(NUM_Q), .BLK(BLK), .LOOK(LOOK), .CAP(CAP)) u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_qid_i,
    .dly_valid_o, .dly_qid_o, .rd_valid_o, .rd_qid_o, .occ_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int occ_of(input int q);
    return int'(occ_o[q*OCC_W +: OCC_W]);
  endfunction

  // drive one slot, check the port-level rules, advance one cycle
  task automatic step(input logic v, input logic [QID_W-1:0] q);
    bit any_room;
    int dec_q;
    req_valid_i = v;
    req_qid_i   = q;
    hv[cyc % HIST] = v;
    hq[cyc % HIST] = q;
    if (cyc >= LOOK) begin
      chk(dly_valid_o == hv[(cyc-LOOK) % HIST], "R1 delayed valid",
          int'(dly_valid_o), int'(hv[(cyc-LOOK) % HIST]));
      if (hv[(cyc-LOOK) % HIST])
        chk(dly_qid_o == hq[(cyc-LOOK) % HIST], "R1 delayed queue",
            int'(dly_qid_o), int'(hq[(cyc-LOOK) % HIST]));
    end else begin
      chk(!dly_valid_o, "R1 nothing before delay", int'(dly_valid_o), 0);
    end
    any_room = 1'b0;
    for (int k = 0; k < NUM_Q; k++) begin
      chk(occ_of(k) == m_occ[k], "R6 occupancy model", occ_of(k), m_occ[k]);
      chk(occ_of(k) <= CAP, "R6 cap", occ_of(k), CAP);
      if (occ_of(k) <= CAP - BLK) any_room = 1'b1;
    end
    if (rd_valid_o) begin
      chk((cyc % BLK) == BLK - 1, "R2 decision slot", cyc % BLK, BLK - 1);
      chk(occ_of(int'(rd_qid_o)) <= CAP - BLK, "R5 room on read",
          occ_of(int'(rd_qid_o)), CAP - BLK);
    end
    if ((cyc % BLK) == BLK - 1)
      chk(rd_valid_o == any_room, "R5 read iff room", int'(rd_valid_o), int'(any_room));
    if (dly_valid_o)
      chk(occ_of(int'(dly_qid_o)) >= 1, "R8 byte present", occ_of(int'(dly_qid_o)), 1);
    dec_q = int'(dly_qid_o);
    if (dly_valid_o && m_occ[dec_q] > 0) m_occ[dec_q] = m_occ[dec_q] - 1;
    if (rd_valid_o) m_occ[int'(rd_qid_o)] = m_occ[int'(rd_qid_o)] + BLK;
    @(posedge clk_i);
    @(negedge clk_i);
    cyc++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NUM_Q; k++) m_occ[k] = 0;
    @(negedge clk_i);
    // R7 reset state
    chk(!dly_valid_o, "R7 reset dly", int'(dly_valid_o), 0);
    chk(!rd_valid_o, "R7 reset rd", int'(rd_valid_o), 0);
    chk(occ_o == '0, "R7 reset occupancy", int'(occ_o), 0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // hand-worked: earliest shortage, then deficit fallback with ties
    for (int r = 0; r < 20; r++) begin
      logic [8:0] row;
      row = VEC[r];
      if (row[5] == 1'b1 && (r == 3 || r == 7))
        chk(rd_valid_o && rd_qid_o == row[4:3], "R3 earliest critical", int'(rd_qid_o), int'(row[4:3]));
      else if (row[5] == 1'b1)
        chk(rd_valid_o && rd_qid_o == row[4:3], "R4 largest deficit", int'(rd_qid_o), int'(row[4:3]));
      else
        chk(!rd_valid_o, "R2 no read", int'(rd_valid_o), 0);
      chk(dly_valid_o == row[2], "R1 table valid", int'(dly_valid_o), int'(row[2]));
      if (row[2]) chk(dly_qid_o == row[1:0], "R1 table queue", int'(dly_qid_o), int'(row[1:0]));
      step(row[8], row[7:6]);
    end

    // idle until every queue is out of room
    for (int i = 0; i < 80; i++) step(1'b0, '0);
    chk(occ_of(0) == 12, "R5 saturate q0", occ_of(0), 12);
    chk(occ_of(1) == 10, "R5 saturate q1", occ_of(1), 10);
    chk(occ_of(2) == 11, "R5 saturate q2", occ_of(2), 11);
    chk(occ_of(3) == 12, "R5 saturate q3", occ_of(3), 12);

    // steady demand on one queue
    for (int i = 0; i < 64; i++) step(1'b1, 2'd0);
    // spread demand
    for (int i = 0; i < 64; i++) step(1'b1, QID_W'(i % NUM_Q));
    // rotating bursts of eight
    for (int i = 0; i < 64; i++) step(1'b1, QID_W'((i / 8) % NUM_Q));
    // sparse mix then drain
    for (int i = 0; i < 32; i++) step(i % 3 != 0, QID_W'((i * 3) % NUM_Q));
    for (int i = 0; i < 40; i++) step(1'b0, '0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule